// File: doc/BRIEF.md
# Accumulator Register-Operation Execution Unit

This block carries out the register-operation class of instructions of a small accumulator machine. It holds a 16-bit accumulator and a one-bit extension flag that sits beside it as a carry or rotate bit. Instruction fetch, decode and memory belong to the surrounding control. That control raises a one-cycle execute strobe once it has classified the instruction as a register operation, and it presents the 12-bit operand field alongside it. Each bit of that field names one micro-operation.

In the strobe cycle the unit decides from the current accumulator and flag whether the next instruction is to be skipped. It also flags a halt request and a sequence-restart pulse. On the closing clock edge it writes the new accumulator and flag. The sequencer uses the skip pulse to bump the program counter. It uses the halt pulse to drop its run flip-flop, which only an external manual action sets again. Every operation completes in the single strobe cycle.

Only one operand bit may be set per strobe. With more than one bit set the outcome is not defined.

Top module: `acc_regref_unit`

## Requirements
- R1: While rst_ni is low and after its release, ac_o is 0 and e_o is 0. With no strobe, skip_o, halt_o and seq_clr_o are 0.
- R2: Operand bit 11 sets ac_o to 0 on the edge that closes the strobe cycle. Bit 10 sets e_o to 0 on that edge.
- R3: Operand bit 9 inverts every bit of ac_o. Bit 8 inverts e_o.
- R4: Operand bit 7 rotates right through the flag. The new ac_o is {old e_o, old ac_o[15:1]} and the new e_o is old ac_o[0].
- R5: Operand bit 6 rotates left through the flag. The new ac_o is {old ac_o[14:0], old e_o} and the new e_o is old ac_o[15].
- R6: Operand bit 5 adds one to ac_o modulo 2^16, so 16'hFFFF wraps to 0. e_o is unchanged.
- R7: skip_o is high during the strobe cycle, and only then, when the selected test holds on the values before the update. Bit 4 tests ac_o[15]=0, bit 3 tests ac_o[15]=1, bit 2 tests ac_o=0 and bit 1 tests e_o=0. These four bits leave ac_o and e_o unchanged.
- R8: Operand bit 0 raises halt_o during the strobe cycle only and leaves ac_o and e_o unchanged.
- R9: seq_clr_o is high in every strobe cycle and low otherwise, so each operation takes exactly one cycle.
- R10: Without the strobe, ac_o and e_o hold their values and skip_o and halt_o stay low, whatever the operand field carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe for a register operation |
| op_field_i | input | 12 | Operand field, one bit per micro-operation |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Extension flag |
| skip_o | output | 1 | Skip request for the program counter, during the strobe cycle |
| halt_o | output | 1 | Halt request to the run flip-flop, during the strobe cycle |
| seq_clr_o | output | 1 | Sequence-counter restart, during the strobe cycle |

## Verification
The checker relies on the operand field having exactly one bit set whenever exec_i is high. Every per-operation property therefore triggers on one bit together with a population count of one. Outside the strobe the field may hold any value, and the hold and quiet-output properties cover that case. The stimulus drives only single-bit fields with the strobe, and it drives all-ones and arbitrary fields without it. A scoreboard model derived from the requirements supplies the expected values.

// File: rtl/acc_rr_pkg.sv
package acc_rr_pkg;
  localparam int unsigned OP_W = 12;

  // bit position within the operand field; the position is the decode
  typedef enum int unsigned {
    B_HALT    = 0,
    B_SKP_EZ  = 1,
    B_SKP_AZ  = 2,
    B_SKP_NEG = 3,
    B_SKP_POS = 4,
    B_INC     = 5,
    B_ROL     = 6,
    B_ROR     = 7,
    B_INV_E   = 8,
    B_INV_A   = 9,
    B_CLR_E   = 10,
    B_CLR_A   = 11
  } op_bit_e;

  localparam int unsigned N_SKIP = 4;
endpackage

// File: rtl/acc_rr_alu.sv
module acc_rr_alu
  import acc_rr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              e_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              e_o
);
  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    ac_o = ac_i;
    e_o  = e_i;
    // one-hot field assumed; ladder order only matters for illegal fields
    if (op_i[B_CLR_A]) begin
      ac_o = '0;
    end else if (op_i[B_CLR_E]) begin
      e_o = 1'b0;
    end else if (op_i[B_INV_A]) begin
      ac_o = ~ac_i;
    end else if (op_i[B_INV_E]) begin
      e_o = ~e_i;
    end else if (op_i[B_ROR]) begin
      ac_o = {e_i, ac_i[MSB:1]};
      e_o  = ac_i[0];
    end else if (op_i[B_ROL]) begin
      ac_o = {ac_i[MSB-1:0], e_i};
      e_o  = ac_i[MSB];
    end else if (op_i[B_INC]) begin
      ac_o = ac_i + DATA_W'(1);
    end
  end
endmodule

// File: rtl/acc_rr_skip.sv
module acc_rr_skip
  import acc_rr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              exec_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              e_i,
  output logic              skip_o
);
  logic [N_SKIP-1:0] cond;
  logic [N_SKIP-1:0] hit;

  assign cond[B_SKP_EZ-1]  = ~e_i;
  assign cond[B_SKP_AZ-1]  = ~|ac_i;
  assign cond[B_SKP_NEG-1] = ac_i[DATA_W-1];
  assign cond[B_SKP_POS-1] = ~ac_i[DATA_W-1];

  for (genvar g = 0; g < N_SKIP; g++) begin : g_skip
    assign hit[g] = op_i[g+1] & cond[g];
  end

  assign skip_o = exec_i & |hit;
endmodule

// File: rtl/acc_regref_unit.sv
module acc_regref_unit
  import acc_rr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [OP_W-1:0]   op_field_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              e_o,
  output logic              skip_o,
  output logic              halt_o,
  output logic              seq_clr_o
);
  logic [DATA_W-1:0] ac_q, ac_d;
  logic              e_q, e_d;

  acc_rr_alu #(.DATA_W(DATA_W)) i_alu (
    .op_i (op_field_i),
    .ac_i (ac_q),
    .e_i  (e_q),
    .ac_o (ac_d),
    .e_o  (e_d)
  );

  acc_rr_skip #(.DATA_W(DATA_W)) i_skip (
    .exec_i (exec_i),
    .op_i   (op_field_i),
    .ac_i   (ac_q),
    .e_i    (e_q),
    .skip_o (skip_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q <= '0;
      e_q  <= 1'b0;
    end else if (exec_i) begin
      ac_q <= ac_d;
      e_q  <= e_d;
    end
  end

  assign halt_o    = exec_i & op_field_i[B_HALT];
  assign seq_clr_o = exec_i;
  assign ac_o      = ac_q;
  assign e_o       = e_q;
endmodule

// File: rtl/acc_rr_chk.sv
module acc_rr_chk
  import acc_rr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [OP_W-1:0]   op_field_i,
  input logic [DATA_W-1:0] ac_o,
  input logic              e_o,
  input logic              skip_o,
  input logic              halt_o,
  input logic              seq_clr_o
);
  logic legal;
  assign legal = exec_i && ($countones(op_field_i) == 1);

  // R1
  always_comb begin
    if (!rst_ni) reset_state_chk: assert (ac_o == '0 && !e_o);
  end

  // R2
  clr_ac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && op_field_i[B_CLR_A] |=> ac_o == '0);
  // R2
  clr_e_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && op_field_i[B_CLR_E] |=> !e_o);
  // R3
  inv_ac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && op_field_i[B_INV_A] |=> ac_o == ~$past(ac_o) && e_o == $past(e_o));
  // R3
  inv_e_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && op_field_i[B_INV_E] |=> e_o != $past(e_o) && $stable(ac_o));
  // R4
  ror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && op_field_i[B_ROR] |=>
      ac_o == {$past(e_o), $past(ac_o[DATA_W-1:1])} && e_o == $past(ac_o[0]));
  // R5
  rol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && op_field_i[B_ROL] |=>
      ac_o == {$past(ac_o[DATA_W-2:0]), $past(e_o)} && e_o == $past(ac_o[DATA_W-1]));
  // R6
  inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && op_field_i[B_INC] |=> ac_o == $past(ac_o) + DATA_W'(1) && $stable(e_o));
  // R7
  skip_az_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && op_field_i[B_SKP_AZ] |-> skip_o == (ac_o == '0));
  // R7
  skip_ez_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && op_field_i[B_SKP_EZ] |-> skip_o == !e_o);
  // R7
  skip_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> exec_i);
  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal && op_field_i[B_HALT] |=> $stable(ac_o) && $stable(e_o));
  // R8
  halt_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> exec_i && op_field_i[B_HALT]);
  // R9
  seq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_clr_o == exec_i);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(ac_o) && $stable(e_o));
endmodule

bind acc_regref_unit acc_rr_chk #(.DATA_W(DATA_W)) i_acc_rr_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .exec_i     (exec_i),
  .op_field_i (op_field_i),
  .ac_o       (ac_o),
  .e_o        (e_o),
  .skip_o     (skip_o),
  .halt_o     (halt_o),
  .seq_clr_o  (seq_clr_o)
);

// File: tb/test_acc_regref_unit.sv
module test_acc_regref_unit;
  localparam int W = 16;

  typedef struct {
    bit         skip;
    bit         halt;
    bit         sclr;
    logic [W-1:0] ac;
    bit         e;
    string      tag;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         exec_i = 1'b0;
  logic [11:0]  op_field_i = '0;
  logic [W-1:0] ac_o;
  logic         e_o, skip_o, halt_o, seq_clr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  item_t q[$];

  logic [W-1:0] m_ac = '0;
  bit           m_e  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  acc_regref_unit i_acc_regref_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .op_field_i(op_field_i),
    .ac_o(ac_o), .e_o(e_o), .skip_o(skip_o), .halt_o(halt_o), .seq_clr_o(seq_clr_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int b);
    case (b)
      11, 10: return "R2";
      9, 8:   return "R3";
      7:      return "R4";
      6:      return "R5";
      5:      return "R6";
      4, 3, 2, 1: return "R7";
      default: return "R8";
    endcase
  endfunction

  // driver: one cycle per call; b < 0 means no strobe with field f
  task automatic drive(input bit ex, input int b, input logic [11:0] f);
    item_t it;
    @(negedge clk_i);
    exec_i     = ex;
    op_field_i = ex ? (12'd1 << b) : f;
    it.skip = 1'b0; it.halt = 1'b0; it.sclr = ex;
    it.tag  = ex ? tag_of(b) : "R10";
    if (ex) begin
      case (b)
        11: m_ac = '0;
        10: m_e = 1'b0;
        9:  m_ac = ~m_ac;
        8:  m_e = ~m_e;
        7:  begin logic o0; o0 = m_ac[0]; m_ac = {m_e, m_ac[W-1:1]}; m_e = o0; end
        6:  begin logic o15; o15 = m_ac[W-1]; m_ac = {m_ac[W-2:0], m_e}; m_e = o15; end
        5:  m_ac = m_ac + 1'b1;
        4:  it.skip = !m_ac[W-1];
        3:  it.skip = m_ac[W-1];
        2:  it.skip = (m_ac == '0);
        1:  it.skip = !m_e;
        default: it.halt = 1'b1;
      endcase
    end
    it.ac = m_ac; it.e = m_e;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk({it.tag, "/R7 skip"}, W'(skip_o), W'(it.skip));
        chk({it.tag, "/R8 halt"}, W'(halt_o), W'(it.halt));
        chk({it.tag, "/R9 seq_clr"}, W'(seq_clr_o), W'(it.sclr));
        @(posedge clk_i);
        #1;
        chk({it.tag, " ac"}, ac_o, it.ac);
        chk({it.tag, " e"}, W'(e_o), W'(it.e));
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 ac in reset", ac_o, '0);
    chk("R1 e in reset", W'(e_o), '0);
    #10;
    rst_ni = 1'b1;
    #1;
    chk("R1 ac after reset", ac_o, '0);
    chk("R1 skip idle", W'(skip_o), '0);
    chk("R1 halt idle", W'(halt_o), '0);
    chk("R1 seq_clr idle", W'(seq_clr_o), '0);

    drive(1'b0, -1, 12'hFFF);            // R10 ignored field
    drive(1'b1, 11, '0); drive(1'b1, 10, '0);
    drive(1'b1, 2, '0); drive(1'b1, 1, '0); drive(1'b1, 4, '0); drive(1'b1, 3, '0);
    drive(1'b1, 9, '0);                  // FFFF
    drive(1'b1, 3, '0); drive(1'b1, 4, '0); drive(1'b1, 2, '0);
    drive(1'b1, 5, '0);                  // R6 wrap to 0
    drive(1'b1, 8, '0); drive(1'b1, 1, '0);
    drive(1'b1, 6, '0); drive(1'b1, 7, '0); drive(1'b1, 7, '0);
    drive(1'b1, 3, '0);
    drive(1'b1, 9, '0); drive(1'b1, 5, '0); drive(1'b1, 6, '0);
    drive(1'b1, 8, '0);                  // E 1->0
    drive(1'b0, -1, 12'h0A5);
    drive(1'b1, 0, '0);                  // R8
    for (int i = 0; i < 400; i++) begin
      int b;
      b = int'($urandom_range(11, 0));
      if ($urandom_range(3, 0) == 0) drive(1'b0, -1, 12'($urandom));
      else drive(1'b1, b, '0);
    end
    @(negedge clk_i);
    exec_i = 1'b0;
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule